// File: doc/BRIEF.md
# Event Flag Bank

The block keeps a large array of one-bit event flags for a command sequencer. Hardware producers raise a flag with a single-cycle set pulse that carries the flag number. The sequencer sends requests, each with a flag number and a 32-bit option word. The option word can ask the block to hold the request until the flag reaches a given value, to write a new value into the flag, or both. Waiting and writing together give the sequencer an atomic wait-and-consume. A request that asks for neither simply clears the flag.

Each request is a one-cycle strobe and is taken only while the block is idle. The block returns a one-cycle acknowledge once the operation has completed. If the condition already holds, the acknowledge arrives on the cycle after the request. Otherwise the block holds the request and tests the flag on every cycle until the condition is met. A request whose flag number is beyond the bank is acknowledged at once and does nothing, except to raise a sticky error output that only reset clears.

Top module: `evt_flag_bank`

## Requirements
- R1: After reset, every flag reads 0, and both `req_ack` and `err_flag` are 0.
- R2: A `set_valid` pulse whose `set_idx` is below NUM_EVT (1024) makes that flag 1 from the next cycle.
- R3: Option word layout: bit 15 enables waiting, bits 11:0 hold the wait value, bit 31 enables an update, and bits 27:16 hold the update value. Only bit 0 and bit 16 are significant; the other bits of the two value fields are ignored.
- R4: For a wait request whose condition already holds, `req_ack` pulses on the cycle after the request. The flag then takes the update value when updating is enabled, and keeps its value otherwise.
- R5: While a waited flag differs from the wait value, no acknowledge is given. Once the flag changes to match, the flag is written and `req_ack` pulses one cycle later.
- R6: A request with updating enabled and waiting disabled writes the update value at once and is acknowledged on the next cycle.
- R7: A request with neither waiting nor updating enabled clears the flag and is acknowledged on the next cycle.
- R8: A set pulse in the same cycle as a request write to the same flag wins, so the flag ends at 1.
- R9: A request with an index of NUM_EVT or more is acknowledged on the next cycle, changes no flag, and sets `err_flag`, which stays 1 until reset. A set pulse with such an index has no effect.
- R10: `req_ack` is never high for two cycles in a row. A request strobe that arrives while an earlier request is stalled is ignored.
- R11: A wait value of 0 is honoured: a wait for 0 completes while the flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Producer set strobe |
| set_idx | input | IDX_W (12) | Flag number to set |
| req_valid | input | 1 | Sequencer request strobe |
| req_idx | input | IDX_W (12) | Flag number for the request |
| req_opt | input | 32 | Wait and update option word |
| req_ack | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Sticky out-of-range request indicator |

## Verification
The assertions rely on the sequencer driving `req_valid` as a one-cycle strobe and raising it again only after the previous acknowledge. Under that condition, the only request the assertions ever see accepted is one that arrives while the block is idle. The bench keeps to this rule everywhere except in the deliberate busy-time strobe, which the checker treats as ignored. Producer indices may fall out of range and may collide with a request write. The stimulus uses both cases on purpose.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;

  // Bit positions inside the request option word (fixed by the sequencer encoding)
  localparam int unsigned OPT_WAIT_EN  = 15;
  localparam int unsigned OPT_WAIT_VAL = 0;
  localparam int unsigned OPT_UPD_EN   = 31;
  localparam int unsigned OPT_UPD_VAL  = 16;

  typedef struct packed {
    logic wait_en;
    logic wait_val;
    logic upd_en;
    logic upd_val;
  } evt_opt_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } evt_state_t;

  // Only the low bit of each value field matters for a one-bit flag
  function automatic evt_opt_t decode_opt(input logic [31:0] word);
    evt_opt_t o;
    o.wait_en  = word[OPT_WAIT_EN];
    o.wait_val = word[OPT_WAIT_VAL];
    o.upd_en   = word[OPT_UPD_EN];
    o.upd_val  = word[OPT_UPD_VAL];
    return o;
  endfunction

  // Condition met: no wait asked, or flag equals the wanted value
  function automatic logic cond_met(input evt_opt_t o, input logic flag);
    return !o.wait_en || (flag == o.wait_val);
  endfunction

  // Value the flag takes when the request completes
  function automatic logic flag_after(input evt_opt_t o, input logic flag);
    logic v;
    if (o.upd_en)       v = o.upd_val;
    else if (o.wait_en) v = flag;
    else                v = 1'b0;
    return v;
  endfunction

  function automatic logic idx_in_bank(input logic [31:0] idx, input int unsigned depth);
    return idx < depth;
  endfunction

endpackage

// File: rtl/evt_flag_store.sv
module evt_flag_store #(
  parameter int unsigned NUM_EVT = 1024,
  localparam int unsigned LIDX   = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [LIDX-1:0]    set_lidx,
  input  logic               wr_en,
  input  logic [LIDX-1:0]    wr_idx,
  input  logic               wr_val,
  input  logic [LIDX-1:0]    rd_idx,
  output logic               rd_val,
  output logic [NUM_EVT-1:0] flags_o
);

  logic [NUM_EVT-1:0] flags_q;

  // One storage cell per event; set from producers has priority over writes
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic set_hit;
    logic wr_hit;
    assign set_hit = set_en && (set_lidx == LIDX'(i));
    assign wr_hit  = wr_en  && (wr_idx   == LIDX'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)       flags_q[i] <= 1'b0;
      else if (set_hit) flags_q[i] <= 1'b1;
      else if (wr_hit)  flags_q[i] <= wr_val;
    end
  end

  assign rd_val  = flags_q[rd_idx];
  assign flags_o = flags_q;

endmodule

// File: rtl/evt_req_ctrl.sv
module evt_req_ctrl
  import evt_flag_pkg::*;
#(
  parameter int unsigned NUM_EVT = 1024,
  parameter int unsigned IDX_W   = 12,
  localparam int unsigned LIDX   = $clog2(NUM_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [31:0]      req_opt,
  input  logic             rd_val,
  output logic [LIDX-1:0]  rd_idx,
  output logic             wr_en,
  output logic [LIDX-1:0]  wr_idx,
  output logic             wr_val,
  output logic             ack,
  output logic             err,
  output logic             busy,
  output logic             hit
);

  evt_state_t state_q, state_d;
  logic [LIDX-1:0] cur_idx_q;
  evt_opt_t        cur_opt_q;
  evt_opt_t        opt_now;
  logic            accept;
  logic            in_bank;
  logic            oor_take;
  logic            active;
  logic            ack_d;

  assign busy     = (state_q == ST_WAIT);
  assign accept   = req_valid && !busy;
  assign in_bank  = idx_in_bank(32'(req_idx), NUM_EVT);
  assign oor_take = accept && !in_bank;

  // In idle the live request is evaluated; while stalled the held one is
  assign rd_idx  = busy ? cur_idx_q : req_idx[LIDX-1:0];
  assign opt_now = busy ? cur_opt_q : decode_opt(req_opt);
  assign hit     = cond_met(opt_now, rd_val);
  assign active  = busy || (accept && in_bank);

  assign wr_en  = active && hit;
  assign wr_idx = rd_idx;
  assign wr_val = flag_after(opt_now, rd_val);
  assign ack_d  = wr_en || oor_take;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept && in_bank && !hit) state_d = ST_WAIT;
      ST_WAIT: if (hit)                       state_d = ST_IDLE;
      default:                                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_idx_q <= '0;
      cur_opt_q <= '0;
      ack       <= 1'b0;
      err       <= 1'b0;
    end else begin
      state_q <= state_d;
      ack     <= ack_d;
      err     <= err || oor_take;
      if (accept) begin
        cur_idx_q <= req_idx[LIDX-1:0];
        cur_opt_q <= decode_opt(req_opt);
      end
    end
  end

endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import evt_flag_pkg::*;
#(
  parameter int unsigned NUM_EVT = 1024,
  parameter int unsigned IDX_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_valid,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [31:0]      req_opt,
  output logic             req_ack,
  output logic             err_flag
);

  localparam int unsigned LIDX = $clog2(NUM_EVT);

  // Named internal events, visible to the bound checker
  logic               set_en;
  logic [LIDX-1:0]    set_lidx;
  logic [LIDX-1:0]    rd_idx;
  logic               rd_val;
  logic               wr_en;
  logic [LIDX-1:0]    wr_idx;
  logic               wr_val;
  logic               busy;
  logic               hit;
  logic [NUM_EVT-1:0] flags;

  assign set_en   = set_valid && idx_in_bank(32'(set_idx), NUM_EVT);
  assign set_lidx = set_idx[LIDX-1:0];

  evt_req_ctrl #(
    .NUM_EVT (NUM_EVT),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .req_opt   (req_opt),
    .rd_val    (rd_val),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_val    (wr_val),
    .ack       (req_ack),
    .err       (err_flag),
    .busy      (busy),
    .hit       (hit)
  );

  evt_flag_store #(
    .NUM_EVT (NUM_EVT)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (set_en),
    .set_lidx (set_lidx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_val   (wr_val),
    .rd_idx   (rd_idx),
    .rd_val   (rd_val),
    .flags_o  (flags)
  );

endmodule

// File: rtl/evt_flag_bank_chk.sv
module evt_flag_bank_chk #(
  parameter int unsigned NUM_EVT = 1024,
  parameter int unsigned IDX_W   = 12,
  localparam int unsigned LIDX   = $clog2(NUM_EVT)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               set_en,
  input logic [LIDX-1:0]    set_lidx,
  input logic               req_valid,
  input logic [IDX_W-1:0]   req_idx,
  input logic               busy,
  input logic               hit,
  input logic               wr_en,
  input logic [LIDX-1:0]    wr_idx,
  input logic               req_ack,
  input logic               err_flag,
  input logic [NUM_EVT-1:0] flags
);

  logic take_oor;
  logic take_ok;
  assign take_oor = req_valid && !busy && (32'(req_idx) >= NUM_EVT);
  assign take_ok  = req_valid && !busy && (32'(req_idx) <  NUM_EVT);

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> flags[$past(set_lidx)]);

  p_quick_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ok && hit) |=> req_ack);

  p_no_ack_stalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit) |=> !req_ack);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && wr_en && (set_lidx == wr_idx)) |=> flags[$past(wr_idx)]);

  p_oor_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_oor |=> (req_ack && err_flag));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

endmodule

bind evt_flag_bank evt_flag_bank_chk #(
  .NUM_EVT (NUM_EVT),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_en    (set_en),
  .set_lidx  (set_lidx),
  .req_valid (req_valid),
  .req_idx   (req_idx),
  .busy      (busy),
  .hit       (hit),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .req_ack   (req_ack),
  .err_flag  (err_flag),
  .flags     (flags)
);

// File: tb/tb_evt_flag_bank.sv
module tb_evt_flag_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_valid = 1'b0;
  logic [11:0] set_idx = '0;
  logic        req_valid = 1'b0;
  logic [11:0] req_idx = '0;
  logic [31:0] req_opt = '0;
  logic        req_ack;
  logic        err_flag;

  int n_total = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  evt_flag_bank dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_valid (set_valid),
    .set_idx   (set_idx),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .req_opt   (req_opt),
    .req_ack   (req_ack),
    .err_flag  (err_flag)
  );

  // Vector: {pre-set, index, option word, expected flag afterwards}
  localparam int NVEC = 8;
  localparam logic [45:0] VEC [NVEC] = '{
    {1'b1, 12'd5,    32'h8000_8001, 1'b0},  // wait 1, consume to 0 (R4)
    {1'b1, 12'd6,    32'h0000_8001, 1'b1},  // wait 1, no update keeps it (R4)
    {1'b0, 12'd7,    32'h8001_0000, 1'b1},  // update 1 without wait (R6)
    {1'b1, 12'd8,    32'h0000_0000, 1'b0},  // plain clear (R7)
    {1'b0, 12'd9,    32'h8001_8000, 1'b1},  // wait 0 then write 1 (R11)
    {1'b1, 12'd1023, 32'h8000_0000, 1'b0},  // top flag, update 0 (R6)
    {1'b1, 12'd0,    32'h8FFE_0000, 1'b0},  // only bit 16 of update field (R3)
    {1'b0, 12'd10,   32'h0000_8FFE, 1'b0}   // only bit 0 of wait field (R3)
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    set_valid = 1'b0;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic issue(input logic [11:0] idx, input logic [31:0] opt, output logic got);
    @(negedge clk);
    req_valid = 1'b1;
    req_idx   = idx;
    req_opt   = opt;
    @(negedge clk);
    req_valid = 1'b0;
    got = req_ack;
  endtask

  task automatic pulse_set(input logic [11:0] idx);
    @(negedge clk);
    set_valid = 1'b1;
    set_idx   = idx;
    @(negedge clk);
    set_valid = 1'b0;
  endtask

  // Reads a flag through a wait-without-update request; a stall means mismatch
  task automatic probe(input logic [11:0] idx, input logic expv, input string tag);
    logic got;
    issue(idx, expv ? 32'h0000_8001 : 32'h0000_8000, got);
    check(got === 1'b1, tag, int'(!expv), int'(expv));
    if (got !== 1'b1) do_reset();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin : main
    logic got;
    do_reset();

    // R1: reset state
    @(negedge clk);
    check(req_ack === 1'b0, "R1 ack", int'(req_ack), 0);
    check(err_flag === 1'b0, "R1 err", int'(err_flag), 0);
    probe(12'd3, 1'b0, "R1 flag");

    // Table walk: non-stalling requests, ack on next cycle, then flag probe
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][45]) begin
        pulse_set(VEC[i][44:33]);
        probe(VEC[i][44:33], 1'b1, "R2 set");
      end
      issue(VEC[i][44:33], VEC[i][32:1], got);
      check(got === 1'b1, "R4/R6/R7 ack", int'(got), 1);
      probe(VEC[i][44:33], VEC[i][0], "R3/R11 flag");
    end

    // R5: stall until producer sets, then consume
    issue(12'd20, 32'h8000_8001, got);
    check(got === 1'b0, "R5 stall", int'(got), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(req_ack === 1'b0, "R5 hold", int'(req_ack), 0);
    end
    pulse_set(12'd20);
    check(req_ack === 1'b0, "R5 edge", int'(req_ack), 0);
    @(negedge clk);
    check(req_ack === 1'b1, "R5 release", int'(req_ack), 1);
    @(negedge clk);
    check(req_ack === 1'b0, "R10 pulse", int'(req_ack), 0);
    probe(12'd20, 1'b0, "R5 consumed");

    // R10: request during stall ignored
    issue(12'd21, 32'h0000_8001, got);
    check(got === 1'b0, "R5 stall2", int'(got), 0);
    issue(12'd22, 32'h8001_0000, got);
    check(got === 1'b0, "R10 busy ack", int'(got), 0);
    pulse_set(12'd21);
    @(negedge clk);
    check(req_ack === 1'b1, "R5 release2", int'(req_ack), 1);
    probe(12'd22, 1'b0, "R10 ignored");
    probe(12'd21, 1'b1, "R4 kept");

    // R8: set beats a same-cycle write
    pulse_set(12'd30);
    @(negedge clk);
    req_valid = 1'b1; req_idx = 12'd30; req_opt = 32'h8000_8001;
    set_valid = 1'b1; set_idx = 12'd30;
    @(negedge clk);
    req_valid = 1'b0; set_valid = 1'b0;
    check(req_ack === 1'b1, "R8 ack", int'(req_ack), 1);
    probe(12'd30, 1'b1, "R8 wait-consume");
    @(negedge clk);
    req_valid = 1'b1; req_idx = 12'd31; req_opt = 32'h8000_0000;
    set_valid = 1'b1; set_idx = 12'd31;
    @(negedge clk);
    req_valid = 1'b0; set_valid = 1'b0;
    probe(12'd31, 1'b1, "R8 write");

    // R9: out-of-range requests and sets
    issue(12'h400, 32'h8001_0000, got);
    check(got === 1'b1, "R9 ack", int'(got), 1);
    check(err_flag === 1'b1, "R9 err", int'(err_flag), 1);
    probe(12'd0, 1'b0, "R9 no alias");
    pulse_set(12'h401);
    probe(12'd1, 1'b0, "R9 set ignored");
    check(err_flag === 1'b1, "R9 sticky", int'(err_flag), 1);
    do_reset();
    @(negedge clk);
    check(err_flag === 1'b0, "R1 err cleared", int'(err_flag), 0);
    probe(12'd7, 1'b0, "R1 flags cleared");

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule